// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block turns two encoder lines, A and B, into a signed-free position value held in a wide register. Both lines first pass through a two-stage synchroniser. Their edges are then found in the system clock domain. A two-bit source field picks how those edges move the count: full four-edge quadrature decoding, pulse with a direction level, or one-way counting up or down from line A alone. In the one-way modes an edge-rate bit chooses whether only rising edges of A count, or both edges do.

The position is kept between 0 and a host-programmable ceiling, both ends included. Stepping up past the ceiling wraps to zero and raises an overflow flag. Stepping down past zero wraps to the ceiling and raises an underflow flag. A host register port gives write and read access to the position, the ceiling, the decoder control word, the run control word, the interrupt mask and the flags. Flags are cleared by writing ones. A sticky global flag drives the single interrupt line.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, the position reads 0, the ceiling reads all ones, the flag register reads 0, counting is disabled and `irq` is low.
- R2: With source field (decoder control bits 15:14) = 00, each single-line transition along the sequence {A,B} = 00, 10, 11, 01, 00 (A leading) adds one to the position.
- R3: With source field 00, each single-line transition along the reverse sequence (B leading) subtracts one.
- R4: In source 00, a transition in which A and B change in the same synchronised cycle leaves the position unchanged.
- R5: With source field 01, only a rising edge of A counts: up when B is 1, down when B is 0. A falling edge of A and any change of B leave the position unchanged.
- R6: With source field 10 the count goes up, and with 11 it goes down, whatever B does. When decoder control bit 11 is 0, only rising edges of A count. When it is 1, both edges of A count.
- R7: While run control bit 3 is 0, input edges leave the position unchanged.
- R8: Counting up from the ceiling gives 0 and sets flag bit 6 (overflow). Counting down from 0 gives the ceiling and sets flag bit 5 (underflow).
- R9: A host write of the position (address 0) or of the ceiling (address 1) is read back unchanged from the same address. The other addresses are: decoder control 2, run control 3, mask 4, flags 5, clear 6.
- R10: Flag bit 0 (global) becomes set when a flag at bit 6 or 5 is set while its mask bit at the same position is 1. `irq` is high exactly while bit 0 is set. Masked-off flags still show in the flag register.
- R11: Writing 1 to a bit of the clear register clears that flag. A 1 at bit 0 clears the global flag, which sets again if an enabled flag remains set. Writing back the value read from the flags clears all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| irq | output | 1 | Interrupt, follows the global flag |

## Verification
The bench steps the encoder both ways across zero and the ceiling. A design that wraps at the wrong bound, or flags the wrong direction, shows a bad position or a bad flag word. Simultaneous A/B changes are applied to catch a decoder that guesses a direction. Falling edges, B toggles and disabled counting are applied in each mode to expose stray counts. The global flag is cleared alone while an enabled flag is still set, which catches a global flag that stays clear or that clears its source flags along with it. A seeded random quadrature walk under a small ceiling checks that repeated wrapping stays in step with the model.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        SRC_QUAD     = 2'b00,
        SRC_PULSEDIR = 2'b01,
        SRC_UP       = 2'b10,
        SRC_DOWN     = 2'b11
    } src_e;

    localparam int ADDR_W = 3;
    localparam int CSR_W  = 16;

    localparam logic [ADDR_W-1:0] AD_POS  = 3'd0;
    localparam logic [ADDR_W-1:0] AD_MAX  = 3'd1;
    localparam logic [ADDR_W-1:0] AD_DEC  = 3'd2;
    localparam logic [ADDR_W-1:0] AD_RUN  = 3'd3;
    localparam logic [ADDR_W-1:0] AD_MASK = 3'd4;
    localparam logic [ADDR_W-1:0] AD_FLAG = 3'd5;
    localparam logic [ADDR_W-1:0] AD_CLR  = 3'd6;

    localparam int BIT_SRC_LO = 14;
    localparam int BIT_RATE   = 11;
    localparam int BIT_RUN    = 3;
    localparam int BIT_OVF    = 6;
    localparam int BIT_UNF    = 5;
    localparam int BIT_GLB    = 0;

    typedef struct packed {
        logic step;
        logic up;
    } step_t;

    // x4 quadrature direction: new A against old B
    function automatic logic quad_up(input logic a_now, input logic b_old);
        return a_now ^ b_old;
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign d_sync = stab_q;
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
    import qpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  a_s,
    input  logic  b_s,
    input  src_e  src,
    input  logic  both_edges,
    output step_t st
);
    logic a_d, b_d;
    logic a_chg, b_chg, a_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_d <= 1'b0;
            b_d <= 1'b0;
        end else begin
            a_d <= a_s;
            b_d <= b_s;
        end
    end

    assign a_chg  = a_s ^ a_d;
    assign b_chg  = b_s ^ b_d;
    assign a_rise = a_s & ~a_d;

    always_comb begin
        st = '0;
        unique case (src)
            SRC_QUAD: begin
                st.step = a_chg ^ b_chg;
                st.up   = quad_up(a_s, b_d);
            end
            SRC_PULSEDIR: begin
                st.step = a_rise;
                st.up   = b_s;
            end
            SRC_UP: begin
                st.step = both_edges ? a_chg : a_rise;
                st.up   = 1'b1;
            end
            SRC_DOWN: begin
                st.step = both_edges ? a_chg : a_rise;
                st.up   = 1'b0;
            end
            default: st = '0;
        endcase
    end

    // R4: a double transition in quadrature never makes a step
    p_no_double_step_r4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_QUAD && a_chg && b_chg) |-> !st.step);

    // R5: pulse/direction counts only on a rising A
    p_pulse_rise_only_r5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PULSEDIR && st.step) |-> (a_s && !a_d));
endmodule

// File: rtl/qpc_position.sv
module qpc_position
    import qpc_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  step_t            st,
    input  logic             wr_pos,
    input  logic             wr_max,
    input  logic [POS_W-1:0] wdata,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] ceil_v,
    output logic             ovf_evt,
    output logic             unf_evt
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] pos_q, max_q, pos_nx;
    logic             move;

    assign move = cnt_en & st.step & ~wr_pos;

    always_comb begin
        if (st.up) pos_nx = (pos_q == max_q) ? '0 : pos_q + ONE;
        else       pos_nx = (pos_q == '0) ? max_q : pos_q - ONE;
    end

    assign ovf_evt = move &  st.up & (pos_q == max_q);
    assign unf_evt = move & ~st.up & (pos_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            max_q <= '1;
        end else begin
            if (wr_max) max_q <= wdata;
            if (wr_pos)    pos_q <= wdata;
            else if (move) pos_q <= pos_nx;
        end
    end

    assign pos    = pos_q;
    assign ceil_v = max_q;

    // R7: disabled counter holds unless the host writes it
    p_hold_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !wr_pos && !wr_max) |=> $stable(pos_q));

    // R8: up from ceiling lands on zero
    p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && st.step && st.up && !wr_pos && pos_q == max_q) |=> (pos_q == '0));

    // R8: down from zero lands on the ceiling
    p_unf_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && st.step && !st.up && !wr_pos && !wr_max && pos_q == '0)
            |=> (pos_q == $past(max_q)));
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [POS_W-1:0]  host_wdata,
    output logic [POS_W-1:0]  host_rdata,
    output logic              irq
);
    localparam int PAD_W = POS_W - CSR_W;

    logic [1:0]       ab_s;
    step_t            st;
    logic [CSR_W-1:0] dec_q, run_q, mask_q, clr_v, flag_v;
    logic             ovf_q, unf_q, glb_q;
    logic             ovf_evt, unf_evt, armed;
    logic [POS_W-1:0] pos, ceil_v;
    src_e             src;

    qpc_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({enc_a, enc_b}),
        .d_sync  (ab_s)
    );

    assign src = src_e'(dec_q[BIT_SRC_LO +: 2]);

    qpc_decoder u_dec (
        .clk        (clk),
        .rst        (rst),
        .a_s        (ab_s[1]),
        .b_s        (ab_s[0]),
        .src        (src),
        .both_edges (dec_q[BIT_RATE]),
        .st         (st)
    );

    qpc_position #(.POS_W(POS_W)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (run_q[BIT_RUN]),
        .st      (st),
        .wr_pos  (host_wr && host_addr == AD_POS),
        .wr_max  (host_wr && host_addr == AD_MAX),
        .wdata   (host_wdata),
        .pos     (pos),
        .ceil_v  (ceil_v),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt)
    );

    assign clr_v = (host_wr && host_addr == AD_CLR) ? host_wdata[CSR_W-1:0] : '0;
    assign armed = (ovf_q & mask_q[BIT_OVF]) | (unf_q & mask_q[BIT_UNF]);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q  <= '0;
            run_q  <= '0;
            mask_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            glb_q  <= 1'b0;
        end else begin
            if (host_wr && host_addr == AD_DEC)  dec_q  <= host_wdata[CSR_W-1:0];
            if (host_wr && host_addr == AD_RUN)  run_q  <= host_wdata[CSR_W-1:0];
            if (host_wr && host_addr == AD_MASK) mask_q <= host_wdata[CSR_W-1:0];
            ovf_q <= ovf_evt | (ovf_q & ~clr_v[BIT_OVF]);
            unf_q <= unf_evt | (unf_q & ~clr_v[BIT_UNF]);
            glb_q <= clr_v[BIT_GLB] ? 1'b0 : (glb_q | armed);
        end
    end

    always_comb begin
        flag_v          = '0;
        flag_v[BIT_OVF] = ovf_q;
        flag_v[BIT_UNF] = unf_q;
        flag_v[BIT_GLB] = glb_q;
    end

    always_comb begin
        unique case (host_addr)
            AD_POS:  host_rdata = pos;
            AD_MAX:  host_rdata = ceil_v;
            AD_DEC:  host_rdata = {{PAD_W{1'b0}}, dec_q};
            AD_RUN:  host_rdata = {{PAD_W{1'b0}}, run_q};
            AD_MASK: host_rdata = {{PAD_W{1'b0}}, mask_q};
            AD_FLAG: host_rdata = {{PAD_W{1'b0}}, flag_v};
            default: host_rdata = '0;
        endcase
    end

    assign irq = glb_q;

    // R10: global flag only rises after an enabled flag was set
    p_glb_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(glb_q) |-> $past(armed));

    // R11: a clear of overflow without a fresh event empties it
    p_ovf_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_v[BIT_OVF] && !ovf_evt) |=> !ovf_q);

    // R11: a clear of the global flag takes effect on the next cycle
    p_glb_clears_r11: assert property (@(posedge clk) disable iff (rst)
        clr_v[BIT_GLB] |=> !glb_q);
endmodule

// File: tb/test_quad_pos_counter.sv
module test_quad_pos_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] exp_pos, exp_max, rv;

    quad_pos_counter i_quad_pos_counter (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] model_step(logic [31:0] p, logic [31:0] m, bit up);
        if (up) return (p == m) ? 32'd0 : p + 32'd1;
        return (p == 32'd0) ? m : p - 32'd1;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic enc(logic a, logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (4) @(posedge clk);
    endtask

    task automatic chk_pos(string tag);
        rd(3'd0, rv);
        chk(tag, rv, exp_pos);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] qs [4];
        int idx;
        qs[0] = 2'b00; qs[1] = 2'b10; qs[2] = 2'b11; qs[3] = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(3'd0, rv); chk("R1 pos", rv, 32'd0);
        rd(3'd1, rv); chk("R1 max", rv, 32'hFFFF_FFFF);
        rd(3'd5, rv); chk("R1 flags", rv, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        exp_pos = 0; exp_max = 32'hFFFF_FFFF;
        enc(1, 0);
        chk_pos("R1 disabled after reset");
        enc(0, 0);

        // R2 forward quadrature
        wr(3'd3, 32'h8);
        enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
        exp_pos = 4; chk_pos("R2 four up edges");
        // R3 reverse
        enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
        exp_pos = 0; chk_pos("R3 four down edges");
        // R8 underflow then overflow
        enc(0, 1);
        exp_pos = 32'hFFFF_FFFF; chk_pos("R8 underflow wraps to max");
        enc(0, 0);
        exp_pos = 0; chk_pos("R8 overflow wraps to zero");
        rd(3'd5, rv); chk("R8 R10 both flags, masked global", rv, 32'h60);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        // R4 double transitions
        enc(1, 1); enc(0, 0);
        chk_pos("R4 invalid transitions");
        // R11 clear
        wr(3'd6, 32'h60);
        rd(3'd5, rv); chk("R11 clear flags", rv, 32'd0);

        // R5 pulse/direction
        wr(3'd2, 32'h4000);
        enc(0, 1); chk_pos("R5 B change alone");
        enc(1, 1); exp_pos = 1; chk_pos("R5 rise up");
        enc(0, 1); chk_pos("R5 fall ignored");
        enc(0, 0); enc(1, 0); exp_pos = 0; chk_pos("R5 rise down");
        enc(0, 0);

        // R7 disabled
        wr(3'd2, 32'h8000); wr(3'd3, 32'h0);
        enc(1, 0); enc(0, 0);
        chk_pos("R7 no count when disabled");
        wr(3'd3, 32'h8);

        // R6 up/down, edge rate
        enc(1, 0); exp_pos = 1; chk_pos("R6 up rise");
        enc(0, 1); chk_pos("R6 up fall and B ignored");
        enc(0, 0);
        wr(3'd2, 32'h8800);
        enc(1, 0); enc(0, 0); exp_pos = 3; chk_pos("R6 up both edges");
        wr(3'd2, 32'hC000);
        enc(1, 1); enc(0, 0); exp_pos = 2; chk_pos("R6 down rise only");
        wr(3'd2, 32'hC800);
        enc(1, 0); enc(0, 0); exp_pos = 0; chk_pos("R6 down both edges");

        // R9 host access
        wr(3'd0, 32'd5); rd(3'd0, rv); chk("R9 pos readback", rv, 32'd5);
        wr(3'd1, 32'd7); rd(3'd1, rv); chk("R9 max readback", rv, 32'd7);
        rd(3'd2, rv); chk("R9 dec readback", rv, 32'hC800);

        // R10 overflow interrupt
        wr(3'd2, 32'h8000); wr(3'd4, 32'h40); wr(3'd0, 32'd7);
        enc(1, 0); enc(0, 0);
        exp_pos = 0; chk_pos("R8 overflow at small max");
        chk("R10 irq on enabled overflow", {31'd0, irq}, 32'd1);
        rd(3'd5, rv); chk("R10 flag word", rv, 32'h41);
        // R11 global-only clear re-arms
        wr(3'd6, 32'h1);
        @(posedge clk); @(negedge clk);
        chk("R11 global resets while overflow set", {31'd0, irq}, 32'd1);
        rd(3'd5, rv);
        wr(3'd6, rv);
        @(posedge clk); @(negedge clk);
        rd(3'd5, rv); chk("R11 write-back clears all", rv, 32'd0);
        chk("R11 irq low", {31'd0, irq}, 32'd0);
        // R10 underflow interrupt
        wr(3'd4, 32'h20); wr(3'd2, 32'hC000);
        enc(1, 0); enc(0, 0);
        exp_pos = 7; chk_pos("R8 underflow to small max");
        chk("R10 irq on enabled underflow", {31'd0, irq}, 32'd1);
        wr(3'd6, 32'h21);

        // random quadrature walk, R2 R3 R8
        wr(3'd1, 32'd10); wr(3'd0, 32'd0); wr(3'd2, 32'h0);
        exp_max = 10; exp_pos = 0; idx = 0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 60; i++) begin
            bit up;
            up = $urandom % 2;
            idx = up ? (idx + 1) % 4 : (idx + 3) % 4;
            enc(qs[idx][1], qs[idx][0]);
            exp_pos = model_step(exp_pos, exp_max, up);
            chk_pos(up ? "R2 random up" : "R3 random down");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule